// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block models a synchronous static RAM whose read path is flow-through: the word addressed at a clock edge reaches the data output during the cycle that follows that edge. Read and write cycles can follow each other on back-to-back clocks with no idle cycle between them, so every clock carries a transfer. Address, write data, chip selects, the read/write control, the load/advance control, the per-byte write enables and the burst-order select are all taken in by registers on the rising clock edge. A suspend input freezes the whole block for as long as it is held.

A transfer begins with a load cycle, which takes in a full word address. Later advance cycles step a two-bit burst counter that walks through the other words of the aligned four-word block. The walk is either linear or interleaved. The data path is split into an input bus, an output bus and an output enable. A pad ring or an on-chip bus fabric can join these three into one shared bidirectional bus. The output enable is low during write beats and deselected beats, and the bus master drives the write data during those beats.

Top module: `sft_sram`

## Requirements
- R1: Synchronous reset, active high, leaves the block deselected. dq_oe is low during reset and after it. Advance cycles that follow reset with no load between them stay deselected.
- R2: A clock edge with suspend high changes nothing. Every other input is ignored, no memory word is written, and dq_oe and dq_out hold their values. When suspend falls, the frozen cycle resumes where it stopped.
- R3: A load cycle (burst_adv = 0) with all three chip_sel bits high starts a read when wr_n = 1 and a write when wr_n = 0. If any chip_sel bit is low, the load starts a deselected cycle: dq_oe stays low and no word is written.
- R4: An advance cycle (burst_adv = 1) keeps the cycle type of the last load and steps the burst count by one, wrapping from 3 back to 0. A deselected cycle stays deselected through any number of advances.
- R5: With order_ilv = 0 at the load, the beat address bits [1:0] equal (start + count) mod 4. Address bits [AW-1:2] stay equal to those of the loaded address.
- R6: With order_ilv = 1 at the load, the beat address bits [1:0] equal start XOR count. The order is taken at the load edge and holds for the whole burst.
- R7: A read beat whose address was sampled at edge N drives dq_oe high after edge N. During the cycle that ends at edge N+1 it also puts the stored word on dq_out.
- R8: A write beat whose address was sampled at edge N takes its data from dq_in at edge N+1. dq_oe stays low during that beat.
- R9: Byte lane i is dq bits [9i+8:9i]. lane_we[i] = 1 enables the write of that lane. lane_we is sampled with the address of each beat, at loads and at advances alike. Lanes that are not enabled keep their stored value.
- R10: A read may follow a write on the very next cycle, and a write may follow a read, with no idle cycle. A read of the address just written returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| suspend | input | 1 | High freezes all state and ignores the other inputs |
| chip_sel | input | 3 | Chip selects; all must be high at a load to select the block |
| burst_adv | input | 1 | 0 = load a new address, 1 = advance the burst |
| wr_n | input | 1 | Sampled at a load: 0 = write, 1 = read |
| addr | input | AW | Word address, taken at a load |
| lane_we | input | LANES | Per-byte write enable for the current beat |
| order_ilv | input | 1 | Burst order at a load: 1 = interleaved, 0 = linear |
| dq_in | input | LANES*LANE_W | Write data, taken on the edge that ends a write beat |
| dq_out | output | LANES*LANE_W | Read data of the current beat (flow-through) |
| dq_oe | output | 1 | High while a read beat drives the data bus |

## Verification
The hardest situation to reach from the ports is a suspend that lands inside a write beat. In that case the commit edge moves later, and dq_in changes while the block is frozen. The stimulus holds suspend over both read and write beats, varies dq_in and the control inputs on every frozen cycle, and then resumes the burst. The bench model commits only the data present at the real commit edge. Other sequences cover a deselect followed by long runs of advances, reads of an address on the cycle right after its write, and a long random phase that mixes loads, advances, partial lane masks, both burst orders and suspends.

// File: rtl/sft_pkg.sv
package sft_pkg;

    localparam int SFT_AW     = 10;
    localparam int SFT_LANES  = 4;
    localparam int SFT_LANE_W = 9;
    localparam int SFT_NCS    = 3;
    localparam int BURST_W    = 2;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_RD   = 2'd1,
        CYC_WR   = 2'd2
    } cyc_e;

    typedef logic [BURST_W-1:0] bcnt_t;

    function automatic bcnt_t burst_lo(bcnt_t start, bcnt_t cnt, logic ilv);
        return ilv ? (start ^ cnt) : bcnt_t'(start + cnt);
    endfunction

endpackage

// File: rtl/sft_burst.sv
module sft_burst
    import sft_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  logic  load,
    input  bcnt_t start_lo,
    input  logic  ilv_in,
    output bcnt_t beat_lo
);

    bcnt_t start_q;
    bcnt_t cnt_q;
    logic  ilv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            cnt_q   <= '0;
            ilv_q   <= 1'b0;
        end else if (!hold) begin
            if (load) begin
                start_q <= start_lo;
                cnt_q   <= '0;
                ilv_q   <= ilv_in;
            end else begin
                cnt_q   <= cnt_q + bcnt_t'(1);
            end
        end
    end

    assign beat_lo = burst_lo(start_q, cnt_q, ilv_q);

    // R5
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !load && !ilv_q) |=> (beat_lo == bcnt_t'($past(beat_lo) + bcnt_t'(1))));

    // R6
    ilv_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !load && ilv_q) |=>
            ((beat_lo ^ $past(beat_lo)) == ($past(cnt_q) ^ bcnt_t'($past(cnt_q) + bcnt_t'(1)))));

    // R2
    burst_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(beat_lo));

endmodule

// File: rtl/sft_ctrl.sv
module sft_ctrl
    import sft_pkg::*;
#(
    parameter int AW    = SFT_AW,
    parameter int LANES = SFT_LANES,
    parameter int NCS   = SFT_NCS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             suspend,
    input  logic [NCS-1:0]   chip_sel,
    input  logic             burst_adv,
    input  logic             wr_n,
    input  logic [AW-1:BURST_W] addr_hi,
    input  logic [LANES-1:0] lane_we,
    output cyc_e             cyc,
    output logic [AW-1:BURST_W] beat_hi,
    output logic [LANES-1:0] beat_lanes
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc        <= CYC_IDLE;
            beat_hi    <= '0;
            beat_lanes <= '0;
        end else if (!suspend) begin
            beat_lanes <= lane_we;
            if (!burst_adv) begin
                beat_hi <= addr_hi;
                if (&chip_sel) cyc <= wr_n ? CYC_RD : CYC_WR;
                else           cyc <= CYC_IDLE;
            end
        end
    end

    // R2
    ctrl_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        suspend |=> ($stable(cyc) && $stable(beat_hi) && $stable(beat_lanes)));

    // R3
    deselect_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!suspend && !burst_adv && !(&chip_sel)) |=> (cyc == CYC_IDLE));

    // R4
    deselect_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!suspend && burst_adv && cyc == CYC_IDLE) |=> (cyc == CYC_IDLE));

    // R5
    upper_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (!suspend && burst_adv) |=> $stable(beat_hi));

endmodule

// File: rtl/sft_store.sv
module sft_store #(
    parameter int AW     = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    commit,
    input  logic [LANES-1:0]        lanes,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (commit && lanes[g])
                lane_mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[addr];
    end

endmodule

// File: rtl/sft_sram.sv
module sft_sram
    import sft_pkg::*;
#(
    parameter int AW     = SFT_AW,
    parameter int LANES  = SFT_LANES,
    parameter int LANE_W = SFT_LANE_W,
    parameter int NCS    = SFT_NCS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    suspend,
    input  logic [NCS-1:0]          chip_sel,
    input  logic                    burst_adv,
    input  logic                    wr_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        lane_we,
    input  logic                    order_ilv,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);

    localparam int DW = LANES * LANE_W;

    cyc_e                 cyc;
    logic [AW-1:BURST_W]  beat_hi;
    bcnt_t                beat_lo;
    logic [LANES-1:0]     beat_lanes;
    logic [AW-1:0]        beat_addr;
    logic                 commit;

    sft_ctrl #(.AW(AW), .LANES(LANES), .NCS(NCS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .suspend    (suspend),
        .chip_sel   (chip_sel),
        .burst_adv  (burst_adv),
        .wr_n       (wr_n),
        .addr_hi    (addr[AW-1:BURST_W]),
        .lane_we    (lane_we),
        .cyc        (cyc),
        .beat_hi    (beat_hi),
        .beat_lanes (beat_lanes)
    );

    sft_burst u_burst (
        .clk      (clk),
        .rst      (rst),
        .hold     (suspend),
        .load     (!burst_adv),
        .start_lo (addr[BURST_W-1:0]),
        .ilv_in   (order_ilv),
        .beat_lo  (beat_lo)
    );

    assign beat_addr = {beat_hi, beat_lo};
    assign commit    = !suspend && (cyc == CYC_WR);

    sft_store #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk    (clk),
        .commit (commit),
        .lanes  (beat_lanes),
        .addr   (beat_addr),
        .wdata  (dq_in),
        .rdata  (dq_out)
    );

    assign dq_oe = (cyc == CYC_RD);

    // R7
    read_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (!suspend && !burst_adv && (&chip_sel) && wr_n) |=> dq_oe);

    // R8
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!suspend && !burst_adv && (&chip_sel) && !wr_n) |=> !dq_oe);

    // R10
    raw_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        (commit && (&beat_lanes)) |=>
            (!(dq_oe && beat_addr == $past(beat_addr)) || dq_out == DW'($past(dq_in))));

endmodule

// File: tb/sft_sram_tb.sv
module sft_sram_tb;

    localparam int AW = 10;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst;
    logic          suspend;
    logic [2:0]    chip_sel;
    logic          burst_adv;
    logic          wr_n;
    logic [AW-1:0] addr;
    logic [3:0]    lane_we;
    logic          order_ilv;
    logic [DW-1:0] dq_in;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    sft_sram u_dut (
        .clk(clk), .rst(rst), .suspend(suspend), .chip_sel(chip_sel),
        .burst_adv(burst_adv), .wr_n(wr_n), .addr(addr), .lane_we(lane_we),
        .order_ilv(order_ilv), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // behavioural reference
    logic [DW-1:0] m_mem   [1024];
    logic [DW-1:0] m_known [1024];
    bit            m_act, m_wr, m_ilv;
    logic [AW-1:0] m_base;
    int            m_cnt;
    logic [3:0]    m_lanes;

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] c = 2'(m_cnt);
        logic [1:0] lo = m_ilv ? (m_base[1:0] ^ c) : 2'(m_base[1:0] + c);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic check_out();
        bit exp_oe = m_act && !m_wr;
        checks++;
        if (dq_oe !== exp_oe) begin
            fails++;
            $display("FAIL %s dq_oe actual=%0b expected=%0b", tag, dq_oe, exp_oe);
        end else if (exp_oe) begin
            logic [AW-1:0] a = m_addr();
            if (((dq_out ^ m_mem[a]) & m_known[a]) != '0) begin
                fails++;
                $display("FAIL %s dq_out addr=%0d actual=%h expected=%h mask=%h",
                         tag, a, dq_out, m_mem[a], m_known[a]);
            end
        end
    endtask

    task automatic cyc(input bit s, input logic [2:0] cs, input bit adv, input bit w,
                       input logic [AW-1:0] ad, input logic [3:0] le, input bit il);
        logic [63:0] r;
        suspend = s; chip_sel = cs; burst_adv = adv; wr_n = w;
        addr = ad; lane_we = le; order_ilv = il;
        r = {$urandom(), $urandom()};
        dq_in = (m_act && m_wr) ? r[DW-1:0] : '0;
        @(posedge clk);
        if (!s) begin
            if (m_act && m_wr) begin
                logic [AW-1:0] a = m_addr();
                for (int l = 0; l < 4; l++) begin
                    if (m_lanes[l]) begin
                        m_mem[a][l*9 +: 9]   = dq_in[l*9 +: 9];
                        m_known[a][l*9 +: 9] = 9'h1ff;
                    end
                end
            end
            if (!adv) begin
                m_act = (cs == 3'b111); m_wr = !w; m_base = ad; m_cnt = 0; m_ilv = il;
            end else begin
                m_cnt++;
            end
            m_lanes = le;
        end
        @(negedge clk);
        check_out();
    endtask

    task automatic load(input logic [2:0] cs, input bit w, input logic [AW-1:0] ad,
                        input logic [3:0] le, input bit il);
        cyc(1'b0, cs, 1'b0, w, ad, le, il);
    endtask

    task automatic adv(input logic [3:0] le);
        cyc(1'b0, 3'b111, 1'b1, 1'b1, '0, le, 1'b0);
    endtask

    task automatic burst(input bit w, input logic [AW-1:0] ad, input bit il);
        load(3'b111, w, ad, 4'hf, il);
        for (int k = 0; k < 3; k++) adv(4'hf);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin m_mem[i] = '0; m_known[i] = '0; end
        m_act = 0; m_wr = 0; m_ilv = 0; m_base = '0; m_cnt = 0; m_lanes = '0;
        rst = 1'b1; suspend = 0; chip_sel = 0; burst_adv = 0; wr_n = 1;
        addr = '0; lane_we = '0; order_ilv = 0; dq_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        tag = "R1"; check_out();
        rst = 1'b0;
        for (int k = 0; k < 3; k++) adv(4'hf);          // R1: no load yet

        tag = "R8";                                       // fill 0..31 by write bursts
        for (int b = 0; b < 8; b++) burst(1'b0, AW'(b*4), 1'b0);

        tag = "R5";                                       // linear: 5,6,7,4 and 14,15,12,13
        burst(1'b1, 10'd5, 1'b0);
        burst(1'b1, 10'd14, 1'b0);

        tag = "R6";                                       // interleaved: 6,7,4,5 and 9,8,11,10
        burst(1'b1, 10'd6, 1'b1);
        burst(1'b1, 10'd9, 1'b1);
        burst(1'b0, 10'd19, 1'b1);                        // interleaved write 19,18,17,16
        burst(1'b1, 10'd16, 1'b0);

        tag = "R9";                                       // lane masks per beat
        load(3'b111, 1'b0, 10'd3, 4'b0101, 1'b0);
        adv(4'b1010); adv(4'b0000); adv(4'b1000);
        burst(1'b1, 10'd3, 1'b0);

        tag = "R10";                                      // write/read alternation
        for (int i = 0; i < 6; i++) begin
            load(3'b111, 1'b0, AW'(20 + i), 4'hf, 1'b0);
            load(3'b111, 1'b1, AW'(20 + i), 4'hf, 1'b0);
        end
        load(3'b111, 1'b1, 10'd2, 4'hf, 1'b0);
        load(3'b111, 1'b0, 10'd2, 4'hf, 1'b0);
        load(3'b111, 1'b1, 10'd2, 4'hf, 1'b0);

        tag = "R3";                                       // deselected writes leave memory alone
        load(3'b101, 1'b0, 10'd2, 4'hf, 1'b0); adv(4'hf); adv(4'hf);
        load(3'b011, 1'b0, 10'd9, 4'hf, 1'b0);
        load(3'b110, 1'b1, 10'd9, 4'hf, 1'b0);
        burst(1'b1, 10'd8, 1'b0);
        burst(1'b1, 10'd0, 1'b0);

        tag = "R4";                                       // deselect stays through advances
        load(3'b000, 1'b1, 10'd4, 4'hf, 1'b0);
        for (int k = 0; k < 6; k++) adv(4'hf);
        load(3'b111, 1'b1, 10'd12, 4'hf, 1'b0);
        for (int k = 0; k < 6; k++) adv(4'hf);          // wraps past 3

        tag = "R2";                                       // suspend in read and write beats
        load(3'b111, 1'b1, 10'd8, 4'hf, 1'b1);
        adv(4'hf);
        for (int k = 0; k < 3; k++) cyc(1'b1, 3'b111, 1'b0, 1'b0, 10'd0, 4'hf, 1'b0);
        adv(4'hf); adv(4'hf);
        load(3'b111, 1'b0, 10'd24, 4'b0011, 1'b0);
        for (int k = 0; k < 3; k++) cyc(1'b1, 3'b000, 1'b0, 1'b1, 10'd30, 4'hf, 1'b1);
        adv(4'b1100);
        cyc(1'b1, 3'b111, 1'b0, 1'b1, 10'd1, 4'h0, 1'b0);
        adv(4'hf);
        burst(1'b1, 10'd24, 1'b0);

        tag = "R7";                                       // random mix
        for (int i = 0; i < 600; i++) begin
            bit s  = ($urandom() % 7) == 0;
            bit a  = ($urandom() % 3) != 0;
            logic [2:0] cs = (($urandom() % 6) == 0) ? 3'($urandom()) : 3'b111;
            cyc(s, cs, a, 1'($urandom()), AW'($urandom() % 32), 4'($urandom()), 1'($urandom()));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule